// File: doc/BRIEF.md
# Trigger Output Pulser

This block drives one trigger output pin from an event source that is picked at run time. Four of the sources are strobes: a synchronized external trigger input, the internal trigger-condition pulse, a front-panel button strobe and a host software strobe. Each strobe launches an output pulse of fixed width. The width is either one microsecond or one millisecond. Both widths are turned into clock counts from the clock-frequency parameter. Two more sources are levels. One keeps the output active while an acquisition runs. The other keeps it active only once that acquisition has also been triggered.

The external trigger input is first brought into the clock domain by a synchronizer chain. Its active polarity is then applied, and only a transition into the active level counts as an event. The logical output is turned into a pad data bit and a pad enable bit. Four styles are offered: push-pull active high, push-pull active low, open-drain, or fully released. A strobe that arrives while a pulse is still running restarts the full width, so close events merge into one longer pulse.

Top module: `trig_out_pulser`

## Requirements
- R1: While reset is asserted, and right after it is released, the output is inactive. In push-pull active-high style this means pin_o=0 and pin_oe_o=1.
- R2: With `cfg_long_i`=0 and a strobe source selected (code 1 = condition, 2 = button, 3 = host), a strobe high for one cycle makes the output active from the next clock edge. It stays active for exactly CLK_HZ×SHORT_NS/1e9 cycles (50 at 50 MHz).
- R3: With `cfg_long_i`=1 the pulse lasts exactly CLK_HZ×LONG_NS/1e9 cycles (50000 at 50 MHz).
- R4: A strobe on the selected source during a running pulse reloads the full width. The output then stays active without a gap until one full width after the last strobe.
- R5: Only the selected source launches a pulse. Strobes and edges on the other inputs leave the output inactive.
- R6: With source code 0, the external input passes through a two-stage synchronizer. `cfg_in_pol_i`=0 makes a rising edge the event and 1 makes a falling edge the event. The output turns active after the third clock edge that samples the new level.
- R7: With source code 4, the output follows `acq_active_i` with one clock of delay.
- R8: With source code 5, the output follows `acq_active_i` AND `acq_triggered_i` with one clock of delay.
- R9: Drive code 0 gives pin_oe_o=1 and pin_o=active. Drive code 1 gives pin_oe_o=1 and pin_o=NOT active.
- R10: Drive code 2 (open-drain) gives pin_o=0 always, with pin_oe_o=active. Drive code 3 gives pin_o=0 and pin_oe_o=0 always.
- R11: Source codes 6 and 7 keep the output inactive whatever the inputs do.
- R12: An external input held at its active level gives exactly one pulse, however long it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_trig_i | input | 1 | External trigger input, asynchronous |
| cond_trig_i | input | 1 | Trigger-condition strobe |
| button_trig_i | input | 1 | Button strobe |
| host_trig_i | input | 1 | Host software strobe |
| acq_active_i | input | 1 | Acquisition running level |
| acq_triggered_i | input | 1 | Acquisition triggered level |
| cfg_src_i | input | 3 | Source select code (0..7) |
| cfg_long_i | input | 1 | 0: short pulse, 1: long pulse |
| cfg_drive_i | input | 2 | Drive style code (0..3) |
| cfg_in_pol_i | input | 1 | External input polarity, 1 = active low |
| pin_o | output | 1 | Pad data |
| pin_oe_o | output | 1 | Pad output enable |

## Verification
The hardest situation to reach from the ports is a retrigger that lands in the middle of a running pulse. The test must show that the output never drops and that the width restarts from the second strobe. The bench places the second strobe a counted number of edges after the first and checks the length of the single merged active run. The polarity corner is reached by changing the external polarity while the input sits still. That change produces an edge with no input transition, and the cycle-level reference model covers it as well.

// File: rtl/trig_out_pkg.sv
package trig_out_pkg;

   typedef enum logic [2:0] {
      SRC_EXT      = 3'd0,
      SRC_COND     = 3'd1,
      SRC_BUTTON   = 3'd2,
      SRC_HOST     = 3'd3,
      SRC_ACQ      = 3'd4,
      SRC_ACQ_POST = 3'd5,
      SRC_OFF_A    = 3'd6,
      SRC_OFF_B    = 3'd7
   } src_e;

   typedef enum logic [1:0] {
      DRV_PP_HIGH    = 2'd0,
      DRV_PP_LOW     = 2'd1,
      DRV_OPEN_DRAIN = 2'd2,
      DRV_RELEASED   = 2'd3
   } drv_e;

   // rounded conversion of a duration in ns to clock cycles
   function automatic longint unsigned ns_to_cycles(input longint unsigned clk_hz,
                                                    input longint unsigned dur_ns);
      return (clk_hz * dur_ns + 64'd500_000_000) / 64'd1_000_000_000;
   endfunction

endpackage

// File: rtl/trig_in_cond.sv
module trig_in_cond #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic pol_i,
   output logic evt_o
);

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   act_lvl;
   logic                   prev_q;

   generate
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= pin_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= 1'b0;
               else        chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   assign act_lvl = chain_q[SYNC_STAGES-1] ^ pol_i;

   // previous level starts high so reset alone never counts as an edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= act_lvl;
   end

   assign evt_o = act_lvl & ~prev_q;

endmodule

// File: rtl/trig_src_sel.sv
module trig_src_sel
   import trig_out_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] src_i,
   input  logic       ext_evt_i,
   input  logic       cond_i,
   input  logic       button_i,
   input  logic       host_i,
   input  logic       acq_active_i,
   input  logic       acq_trig_i,
   output logic       pulse_evt_o,
   output logic       lvl_q_o,
   output logic       pulse_kind_o,
   output logic       level_kind_o
);

   src_e src;
   logic lvl_d;

   assign src = src_e'(src_i);

   always_comb begin
      pulse_evt_o  = 1'b0;
      lvl_d        = 1'b0;
      pulse_kind_o = 1'b0;
      level_kind_o = 1'b0;
      unique case (src)
         SRC_EXT:      begin pulse_kind_o = 1'b1; pulse_evt_o = ext_evt_i; end
         SRC_COND:     begin pulse_kind_o = 1'b1; pulse_evt_o = cond_i;    end
         SRC_BUTTON:   begin pulse_kind_o = 1'b1; pulse_evt_o = button_i;  end
         SRC_HOST:     begin pulse_kind_o = 1'b1; pulse_evt_o = host_i;    end
         SRC_ACQ:      begin level_kind_o = 1'b1; lvl_d = acq_active_i; end
         SRC_ACQ_POST: begin level_kind_o = 1'b1; lvl_d = acq_active_i & acq_trig_i; end
         default:      ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q_o <= 1'b0;
      else        lvl_q_o <= lvl_d;
   end

endmodule

// File: rtl/trig_width_timer.sv
module trig_width_timer #(
   parameter int unsigned SHORT_CYC = 100,
   parameter int unsigned LONG_CYC  = 100000,
   localparam int unsigned CNT_W    = $clog2(LONG_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic long_i,
   output logic busy_o
);

   localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_CYC - 1);
   localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_CYC - 1);

   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         busy_o <= 1'b0;
      end else if (evt_i) begin
         left_q <= long_i ? LONG_LOAD : SHORT_LOAD;
         busy_o <= 1'b1;
      end else if (busy_o) begin
         if (left_q == '0) busy_o <= 1'b0;
         else              left_q <= left_q - 1'b1;
      end
   end

endmodule

// File: rtl/trig_pad_drive.sv
module trig_pad_drive
   import trig_out_pkg::*;
(
   input  logic       act_i,
   input  logic [1:0] drive_i,
   output logic       pin_o,
   output logic       pin_oe_o
);

   always_comb begin
      unique case (drv_e'(drive_i))
         DRV_PP_HIGH:    begin pin_o = act_i;  pin_oe_o = 1'b1;  end
         DRV_PP_LOW:     begin pin_o = ~act_i; pin_oe_o = 1'b1;  end
         DRV_OPEN_DRAIN: begin pin_o = 1'b0;   pin_oe_o = act_i; end
         default:        begin pin_o = 1'b0;   pin_oe_o = 1'b0;  end
      endcase
   end

endmodule

// File: rtl/trig_out_pulser.sv
module trig_out_pulser #(
   parameter longint unsigned CLK_HZ      = 100_000_000,
   parameter longint unsigned SHORT_NS    = 1_000,
   parameter longint unsigned LONG_NS     = 1_000_000,
   parameter int unsigned     SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ext_trig_i,
   input  logic       cond_trig_i,
   input  logic       button_trig_i,
   input  logic       host_trig_i,
   input  logic       acq_active_i,
   input  logic       acq_triggered_i,
   input  logic [2:0] cfg_src_i,
   input  logic       cfg_long_i,
   input  logic [1:0] cfg_drive_i,
   input  logic       cfg_in_pol_i,
   output logic       pin_o,
   output logic       pin_oe_o
);

   localparam int unsigned SHORT_CYC = int'(trig_out_pkg::ns_to_cycles(CLK_HZ, SHORT_NS));
   localparam int unsigned LONG_CYC  = int'(trig_out_pkg::ns_to_cycles(CLK_HZ, LONG_NS));

   generate
      if (SHORT_CYC < 2)         begin : g_bad_short  $error("short pulse under two cycles"); end
      if (LONG_CYC < SHORT_CYC)  begin : g_bad_long   $error("long pulse shorter than short pulse"); end
      if (SYNC_STAGES < 2)       begin : g_bad_sync   $error("synchronizer needs two stages"); end
   endgenerate

   logic ext_evt, pulse_evt, lvl_q, pulse_kind, level_kind, busy, act;

   trig_in_cond #(.SYNC_STAGES(SYNC_STAGES)) u_in (
      .clk(clk), .rst_n(rst_n), .pin_i(ext_trig_i), .pol_i(cfg_in_pol_i), .evt_o(ext_evt)
   );

   trig_src_sel u_sel (
      .clk(clk), .rst_n(rst_n), .src_i(cfg_src_i), .ext_evt_i(ext_evt),
      .cond_i(cond_trig_i), .button_i(button_trig_i), .host_i(host_trig_i),
      .acq_active_i(acq_active_i), .acq_trig_i(acq_triggered_i),
      .pulse_evt_o(pulse_evt), .lvl_q_o(lvl_q),
      .pulse_kind_o(pulse_kind), .level_kind_o(level_kind)
   );

   trig_width_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .evt_i(pulse_evt), .long_i(cfg_long_i), .busy_o(busy)
   );

   assign act = (pulse_kind & busy) | (level_kind & lvl_q);

   trig_pad_drive u_pad (
      .act_i(act), .drive_i(cfg_drive_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o)
   );

endmodule

// File: rtl/trig_out_pulser_chk.sv
module trig_out_pulser_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cond_trig_i,
   input logic       acq_active_i,
   input logic [2:0] cfg_src_i,
   input logic [1:0] cfg_drive_i,
   input logic       pin_o,
   input logic       pin_oe_o
);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_PP_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_drive_i < 2'd2) |-> pin_oe_o);                                  // R9

   AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_drive_i == 2'd2) |-> !pin_o);                                   // R10

   AST_RELEASED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_drive_i == 2'd3) |-> (!pin_o && !pin_oe_o));                    // R10

   AST_OFF_SOURCE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_src_i >= 3'd6 && cfg_drive_i == 2'd0) |-> !pin_o);              // R11

   AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && cfg_src_i == 3'd4 && $past(cfg_src_i) == 3'd4 && cfg_drive_i == 2'd0)
      |-> (pin_o == $past(acq_active_i)));                                  // R7

   AST_STROBE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_src_i == 3'd1 && cond_trig_i)
      |=> (pin_o || cfg_drive_i != 2'd0 || cfg_src_i != 3'd1));            // R2

endmodule

bind trig_out_pulser trig_out_pulser_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cond_trig_i(cond_trig_i), .acq_active_i(acq_active_i),
   .cfg_src_i(cfg_src_i), .cfg_drive_i(cfg_drive_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o)
);

// File: tb/trig_out_pulser_bench.sv
`timescale 1ns/1ps
module trig_out_pulser_bench;

   localparam longint unsigned CLK_HZ = 50_000_000;
   localparam int SHORT_W = 50;
   localparam int LONG_W  = 50000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext = 1'b0, cond = 1'b0, btn = 1'b0, host = 1'b0, acq = 1'b0, trg = 1'b0;
   logic [2:0] src = 3'd1;
   logic lng = 1'b0;
   logic [1:0] drv = 2'd0;
   logic pol = 1'b0;
   logic pin, oe;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   trig_out_pulser #(.CLK_HZ(CLK_HZ)) u_trig_out_pulser (
      .clk(clk), .rst_n(rst_n), .ext_trig_i(ext), .cond_trig_i(cond),
      .button_trig_i(btn), .host_trig_i(host), .acq_active_i(acq),
      .acq_triggered_i(trg), .cfg_src_i(src), .cfg_long_i(lng),
      .cfg_drive_i(drv), .cfg_in_pol_i(pol), .pin_o(pin), .pin_oe_o(oe)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit dut_act();
      case (drv)
         2'd0: return pin;
         2'd1: return !pin;
         2'd2: return oe;
         default: return 1'b0;
      endcase
   endfunction

   // behavioural reference model, updated on every rising edge
   bit hist[$];
   bit m_prev = 1;
   int m_left = 0;
   bit m_lvl = 0;

   always @(posedge clk) begin
      bit syn, lv, ev, ma, ep, eo;
      if (!rst_n) begin
         hist.delete(); m_prev = 1; m_left = 0; m_lvl = 0;
      end else begin
         syn = (hist.size() >= 2) ? hist[1] : 1'b0;
         lv  = syn ^ pol;
         case (src)
            3'd0: ev = lv && !m_prev;
            3'd1: ev = cond;
            3'd2: ev = btn;
            3'd3: ev = host;
            default: ev = 1'b0;
         endcase
         m_prev = lv;
         hist.push_front(ext);
         if (hist.size() > 3) void'(hist.pop_back());
         if (ev) m_left = lng ? LONG_W : SHORT_W;
         else if (m_left > 0) m_left--;
         m_lvl = (src == 3'd4) ? acq : (src == 3'd5) ? (acq && trg) : 1'b0;
      end
      #1;
      ma = (src <= 3'd3) ? (m_left > 0) : (src <= 3'd5) ? m_lvl : 1'b0;
      case (drv)
         2'd0: begin ep = ma;  eo = 1'b1; end
         2'd1: begin ep = !ma; eo = 1'b1; end
         2'd2: begin ep = 1'b0; eo = ma; end
         default: begin ep = 1'b0; eo = 1'b0; end
      endcase
      if (!done) begin
         chk((drv < 2) ? "R9 model pin" : "R10 model pin", pin, ep);
         chk((drv < 2) ? "R9 model oe"  : "R10 model oe", oe, eo);
      end
   end

   task automatic edge1();
      @(posedge clk); #1;
   endtask

   // raise one input just after an edge, measure latency and width of the run
   task automatic fire(input int which, input bit hold, output int lat, output int wid);
      lat = 0; wid = 0;
      case (which)
         0: ext = ~ext;
         1: cond = 1'b1;
         2: btn = 1'b1;
         default: host = 1'b1;
      endcase
      for (int i = 0; i < 60000; i++) begin
         edge1();
         lat++;
         if (!hold) begin cond = 1'b0; btn = 1'b0; host = 1'b0; end
         if (dut_act()) break;
      end
      wid = 1;
      for (int i = 0; i < 60000; i++) begin
         edge1();
         if (dut_act()) wid++; else break;
      end
   endtask

   task automatic count_idle(input int n, output int cnt);
      cnt = 0;
      for (int i = 0; i < n; i++) begin
         edge1();
         cond = 1'b0; btn = 1'b0; host = 1'b0;
         if (dut_act()) cnt++;
      end
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int lat, wid, cnt;
      repeat (4) @(negedge clk);
      chk("R1 pin in reset", pin, 0);
      chk("R1 oe in reset", oe, 1);
      rst_n = 1'b1;
      edge1();
      chk("R1 pin after reset", pin, 0);

      // R2 short strobe pulse from condition source
      fire(1, 0, lat, wid);
      chk("R2 latency", lat, 1);
      chk("R2 width", wid, SHORT_W);

      // R3 long pulse
      lng = 1'b1;
      fire(1, 0, lat, wid);
      chk("R3 width", wid, LONG_W);
      lng = 1'b0;

      // R4 retrigger 30 edges after the first strobe
      cond = 1'b1; cnt = 0;
      for (int i = 0; i < 200; i++) begin
         edge1();
         if (i == 0 || i == 30) cond = 1'b0;
         if (i == 29) cond = 1'b1;
         if (dut_act()) cnt++; else break;
      end
      chk("R4 merged width", cnt, 30 + SHORT_W);

      // R5 non-selected inputs ignored
      src = 3'd1;
      btn = 1'b1; count_idle(3, cnt); chk("R5 button ignored", cnt, 0);
      host = 1'b1; count_idle(3, cnt); chk("R5 host ignored", cnt, 0);
      ext = 1'b1; count_idle(60, cnt); chk("R5 ext ignored", cnt, 0);
      ext = 1'b0; count_idle(10, cnt);
      src = 3'd2; fire(2, 0, lat, wid); chk("R5 button selected width", wid, SHORT_W);
      src = 3'd3; fire(3, 0, lat, wid); chk("R5 host selected width", wid, SHORT_W);

      // R6 external rising edge, R12 held level gives one pulse
      src = 3'd0; count_idle(5, cnt);
      fire(0, 1, lat, wid);
      chk("R6 ext latency", lat, 3);
      chk("R6 ext width", wid, SHORT_W);
      count_idle(100, cnt); chk("R12 held level no repeat", cnt, 0);
      ext = 1'b0; count_idle(60, cnt); chk("R6 falling edge ignored", cnt, 0);
      pol = 1'b1; count_idle(80, cnt);
      ext = 1'b1; count_idle(10, cnt); chk("R6 rising ignored when active low", cnt, 0);
      fire(0, 1, lat, wid);
      chk("R6 active-low latency", lat, 3);
      chk("R6 active-low width", wid, SHORT_W);

      // R7 acquisition level
      src = 3'd4; acq = 1'b1; edge1(); chk("R7 follows high", dut_act(), 1);
      acq = 1'b0; edge1(); chk("R7 follows low", dut_act(), 0);

      // R8 acquisition after trigger
      src = 3'd5; acq = 1'b1; trg = 1'b0; edge1(); edge1();
      chk("R8 untriggered", dut_act(), 0);
      trg = 1'b1; edge1(); chk("R8 triggered", dut_act(), 1);
      acq = 1'b0; edge1(); chk("R8 acq ended", dut_act(), 0);
      trg = 1'b0;

      // R9 / R10 drive styles, active then inactive
      src = 3'd4; acq = 1'b1; edge1();
      drv = 2'd0; #1; chk("R9 pp-high pin act", pin, 1);
      drv = 2'd1; #1; chk("R9 pp-low pin act", pin, 0); chk("R9 pp-low oe", oe, 1);
      drv = 2'd2; #1; chk("R10 od pin act", pin, 0); chk("R10 od oe act", oe, 1);
      drv = 2'd3; #1; chk("R10 released oe act", oe, 0);
      acq = 1'b0; edge1();
      drv = 2'd2; #1; chk("R10 od oe idle", oe, 0);
      drv = 2'd1; #1; chk("R9 pp-low pin idle", pin, 1);
      drv = 2'd0; #1; chk("R9 pp-high pin idle", pin, 0);

      // R11 disabled source codes
      src = 3'd6; acq = 1'b1; trg = 1'b1;
      cond = 1'b1; btn = 1'b1; host = 1'b1; ext = 1'b0;
      count_idle(60, cnt); chk("R11 code 6 idle", cnt, 0);
      src = 3'd7; cond = 1'b1; ext = 1'b1;
      count_idle(60, cnt); chk("R11 code 7 idle", cnt, 0);
      acq = 1'b0; trg = 1'b0;

      edge1();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule